// File: doc/BRIEF.md
# Rectangle Copy Address Generator

This block walks a rectangular image of `W` by `H` pixels and produces, for each 16-bit word to move, a pair of byte addresses: one in a packed source image and one in a frame buffer `FB_W` pixels wide, at pixel position (x, y). A pixel occupies two or three bytes, chosen per job. The source is read as one unbroken run of words. The destination advances one word at a time inside a row. At the end of each row it makes a single larger jump to the start of the next row.

A job is loaded by a one-cycle `start_i` while the block is idle. Address pairs then leave on a valid/ready stream. A one-cycle `done_o` follows the acceptance of the last pair. The row jump is formed as (frame width − image width) × bytes per pixel + 2, and it is applied in place of the final +2 step of each row. The destination x is rounded down to an even pixel. Memory access itself is left to the consumer of the stream.

Top module: `rect_addr_gen`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `addr_valid_o`, `done_o` and `busy_o` are 0.
- R2: A `start_i` accepted while idle with nonzero width and height raises `addr_valid_o` in the next cycle. The first pair is then `src_addr_o` = `src_base_i` and `dst_addr_o` = `dst_base_i` + (`pos_x_i` with bit 0 forced to 0) × bpp + `pos_y_i` × `FB_W` × bpp.
- R3: Each row holds floor(W × bpp / 2) words and there are H rows, so a job emits exactly that product of pairs.
- R4: Each accepted pair is followed by a source address 2 higher, across row ends as well.
- R5: Within a row, each accepted pair is followed by a destination address 2 higher.
- R6: After the last word of a row is accepted, the next destination address is the previous one plus (`FB_W` − W) × bpp + 2. This step replaces the +2 step rather than adding to it.
- R7: While `addr_valid_o` is 1 and `addr_ready_i` is 0, both addresses and `addr_valid_o` hold.
- R8: In the cycle after the last pair is accepted, `done_o` is 1 for one cycle and `addr_valid_o` and `busy_o` are 0.
- R9: A start with width 0 or height 0 emits no pair and raises `done_o` in the next cycle.
- R10: `start_i` asserted while busy has no effect on the running job's addresses or length.
- R11: `pix3_i` = 1 selects 3 bytes per pixel and `pix3_i` = 0 selects 2. The choice is captured at start.
- R12: Address arithmetic wraps modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load a job when idle |
| src_base_i | input | ADDR_W | Source image byte address |
| dst_base_i | input | ADDR_W | Frame buffer byte address of pixel (0,0) |
| width_i | input | DIM_W | Image width in pixels |
| height_i | input | DIM_W | Image height in rows |
| pos_x_i | input | DIM_W | Destination column; bit 0 ignored |
| pos_y_i | input | DIM_W | Destination row |
| pix3_i | input | 1 | 1: 3 bytes per pixel, 0: 2 bytes |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| addr_valid_o | output | 1 | Address pair valid |
| addr_ready_i | input | 1 | Consumer takes the pair |
| src_addr_o | output | ADDR_W | Source byte address |
| dst_addr_o | output | ADDR_W | Destination byte address |

## Verification
The bench uses the defaults: `FB_W` = 320, `DIM_W` = 10 and `ADDR_W` = 32. With these values a full-width row of 320 pixels, where the row jump collapses to +2, can be reached, and so can positions near the bottom of the frame. Odd widths at 3 bytes per pixel exercise the truncated word count. Odd x values exercise the even rounding. Random base addresses near the top of the address space bring the wrap-around of R12 within reach.

// File: rtl/rect_addr_pkg.sv
package rect_addr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_state_e;

  localparam int unsigned N_LANES = 2;
  localparam int unsigned LANE_SRC = 0;
  localparam int unsigned LANE_DST = 1;
  localparam int unsigned WORD_BYTES = 2;
endpackage

// File: rtl/rect_setup.sv
module rect_setup #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 10,
  parameter int unsigned FB_W   = 320,
  parameter int unsigned CNT_W  = DIM_W + 1
) (
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [DIM_W-1:0]  pos_x_i,
  input  logic [DIM_W-1:0]  pos_y_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              pix3_i,
  output logic [ADDR_W-1:0] dst_start_o,
  output logic [ADDR_W-1:0] dst_row_step_o,
  output logic [CNT_W-1:0]  words_o,
  output logic              empty_o
);
  import rect_addr_pkg::*;

  logic [ADDR_W-1:0] bpp;
  logic [ADDR_W-1:0] x_even;
  logic [ADDR_W-1:0] line_bytes;
  logic [DIM_W+1:0]  row_bytes;

  assign bpp        = pix3_i ? ADDR_W'(3) : ADDR_W'(2);
  assign x_even     = ADDR_W'({pos_x_i[DIM_W-1:1], 1'b0});
  assign line_bytes = ADDR_W'(FB_W) * bpp;

  // width * bpp without a multiplier: 2w, plus w for 3-byte pixels
  assign row_bytes = {1'b0, width_i, 1'b0} + (pix3_i ? {2'b00, width_i} : '0);
  assign words_o   = row_bytes[DIM_W+1:1];

  assign dst_start_o    = dst_base_i + x_even * bpp + ADDR_W'(pos_y_i) * line_bytes;
  assign dst_row_step_o = (ADDR_W'(FB_W) - ADDR_W'(width_i)) * bpp + ADDR_W'(WORD_BYTES);
  assign empty_o        = (width_i == '0) || (height_i == '0);
endmodule

// File: rtl/rect_walk.sv
module rect_walk #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned DIM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] words_i,
  input  logic [DIM_W-1:0] rows_i,
  input  logic             step_i,
  output logic             row_end_o,
  output logic             last_o
);
  logic [CNT_W-1:0] words_q, col_q;
  logic [DIM_W-1:0] rows_q, row_q;

  assign row_end_o = (col_q == words_q - CNT_W'(1));
  assign last_o    = row_end_o && (row_q == rows_q - DIM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      rows_q  <= '0;
      col_q   <= '0;
      row_q   <= '0;
    end else if (load_i) begin
      words_q <= words_i;
      rows_q  <= rows_i;
      col_q   <= '0;
      row_q   <= '0;
    end else if (step_i) begin
      if (row_end_o) begin
        col_q <= '0;
        row_q <= row_q + DIM_W'(1);
      end else begin
        col_q <= col_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rect_addr_acc.sv
module rect_addr_acc #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] outer_step_i,
  input  logic              step_i,
  input  logic              row_end_i,
  output logic [ADDR_W-1:0] addr_o
);
  import rect_addr_pkg::*;

  logic [ADDR_W-1:0] addr_q, outer_q;

  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      outer_q <= '0;
    end else if (load_i) begin
      addr_q  <= start_addr_i;
      outer_q <= outer_step_i;
    end else if (step_i) begin
      // outer step stands in for the last inner step of a row
      addr_q <= addr_q + (row_end_i ? outer_q : ADDR_W'(WORD_BYTES));
    end
  end
endmodule

// File: rtl/rect_addr_gen.sv
module rect_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 10,
  parameter int unsigned FB_W   = 320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [DIM_W-1:0]  pos_x_i,
  input  logic [DIM_W-1:0]  pos_y_i,
  input  logic              pix3_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o
);
  import rect_addr_pkg::*;

  localparam int unsigned CNT_W = DIM_W + 1;

  walk_state_e state_q;
  logic        done_q;
  logic        load, fire, row_end, last, empty;

  logic [ADDR_W-1:0] dst_start, dst_row_step;
  logic [CNT_W-1:0]  words;

  logic [ADDR_W-1:0] lane_start [N_LANES];
  logic [ADDR_W-1:0] lane_outer [N_LANES];
  logic [ADDR_W-1:0] lane_addr  [N_LANES];

  assign load         = start_i && (state_q == ST_IDLE);
  assign addr_valid_o = (state_q == ST_RUN);
  assign fire         = addr_valid_o && addr_ready_i;
  assign busy_o       = (state_q == ST_RUN);
  assign done_o       = done_q;

  rect_setup #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .FB_W(FB_W), .CNT_W(CNT_W)
  ) u_setup (
    .dst_base_i    (dst_base_i),
    .pos_x_i       (pos_x_i),
    .pos_y_i       (pos_y_i),
    .width_i       (width_i),
    .height_i      (height_i),
    .pix3_i        (pix3_i),
    .dst_start_o   (dst_start),
    .dst_row_step_o(dst_row_step),
    .words_o       (words),
    .empty_o       (empty)
  );

  rect_walk #(.CNT_W(CNT_W), .DIM_W(DIM_W)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .words_i  (words),
    .rows_i   (height_i),
    .step_i   (fire),
    .row_end_o(row_end),
    .last_o   (last)
  );

  assign lane_start[LANE_SRC] = src_base_i;
  assign lane_outer[LANE_SRC] = ADDR_W'(WORD_BYTES);
  assign lane_start[LANE_DST] = dst_start;
  assign lane_outer[LANE_DST] = dst_row_step;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    rect_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .start_addr_i(lane_start[g]),
      .outer_step_i(lane_outer[g]),
      .step_i      (fire),
      .row_end_i   (row_end),
      .addr_o      (lane_addr[g])
    );
  end

  assign src_addr_o = lane_addr[LANE_SRC];
  assign dst_addr_o = lane_addr[LANE_DST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (empty) done_q  <= 1'b1;
          else       state_q <= ST_RUN;
        end
        ST_RUN: if (fire && last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rect_addr_gen_chk.sv
module rect_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] src_base_i,
  input logic [DIM_W-1:0]  width_i,
  input logic [DIM_W-1:0]  height_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              addr_valid_o,
  input logic              addr_ready_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o
);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=>
      (addr_valid_o && $stable(src_addr_o) && $stable(dst_addr_o)));

  p_src_contig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && addr_ready_i) |=>
      (!addr_valid_o || src_addr_o == $past(src_addr_o) + ADDR_W'(2)));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!addr_valid_o && !busy_o));

  p_empty_job_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (width_i == '0 || height_i == '0)) |=>
      (done_o && !addr_valid_o));

  p_first_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && width_i != '0 && height_i != '0) |=>
      (addr_valid_o && !done_o && src_addr_o == $past(src_base_i)));

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !addr_ready_i) |=>
      (addr_valid_o && $stable(src_addr_o) && $stable(dst_addr_o)));
endmodule

bind rect_addr_gen rect_addr_gen_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .src_base_i  (src_base_i),
  .width_i     (width_i),
  .height_i    (height_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .addr_valid_o(addr_valid_o),
  .addr_ready_i(addr_ready_i),
  .src_addr_o  (src_addr_o),
  .dst_addr_o  (dst_addr_o)
);

// File: tb/rect_addr_gen_test.sv
module rect_addr_gen_test;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DIM_W  = 10;
  localparam int unsigned FB_W   = 320;
  localparam time CLK_PERIOD     = 10ns;
  localparam int  WATCHDOG       = 150000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] src_base_i = '0, dst_base_i = '0;
  logic [DIM_W-1:0]  width_i = '0, height_i = '0, pos_x_i = '0, pos_y_i = '0;
  logic              pix3_i = 1'b0;
  logic              busy_o, done_o, addr_valid_o;
  logic              addr_ready_i = 1'b0;
  logic [ADDR_W-1:0] src_addr_o, dst_addr_o;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rect_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .FB_W(FB_W)) uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      check(1'b0, "R3", "watchdog expired", 32'(cyc), 32'(WATCHDOG));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [ADDR_W-1:0] f_bpp(input bit p3);
    return p3 ? 32'd3 : 32'd2;
  endfunction

  function automatic int f_words(input int w, input bit p3);
    return (w * (p3 ? 3 : 2)) / 2;
  endfunction

  function automatic logic [ADDR_W-1:0] f_dst(input logic [ADDR_W-1:0] db, input int w,
      input int x, input int y, input bit p3, input int r, input int c);
    logic [ADDR_W-1:0] start, pitch;
    int n;
    n = f_words(w, p3);
    start = db + 32'(x & ~1) * f_bpp(p3) + 32'(y) * 32'(FB_W) * f_bpp(p3);
    pitch = 32'(2 * (n - 1)) + (32'(FB_W) - 32'(w)) * f_bpp(p3) + 32'd2;
    return start + 32'(r) * pitch + 32'(2 * c);
  endfunction

  task automatic run_job(input logic [ADDR_W-1:0] sb, input logic [ADDR_W-1:0] db,
      input int w, input int h, input int x, input int y, input bit p3, input bit poke);
    int n, total, k, guard;
    bit seen_done, rdy;
    n = f_words(w, p3);
    total = n * h;
    @(negedge clk_i);
    src_base_i = sb; dst_base_i = db;
    width_i = DIM_W'(w); height_i = DIM_W'(h);
    pos_x_i = DIM_W'(x); pos_y_i = DIM_W'(y);
    pix3_i = p3; start_i = 1'b1; addr_ready_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    if (total == 0) begin
      check(done_o && !addr_valid_o, "R9", "empty job done/no valid", {30'b0, done_o, addr_valid_o}, 32'h2);
      @(negedge clk_i);
      check(!done_o && !addr_valid_o && !busy_o, "R9", "empty job quiet after", {30'b0, done_o, addr_valid_o}, 32'h0);
      return;
    end
    k = 0; seen_done = 0; guard = 0;
    while (!seen_done && guard < 20000) begin
      start_i = 1'b0;
      if (done_o) begin
        seen_done = 1;
        check(k == total, "R3", "pairs emitted", 32'(k), 32'(total));
        check(!addr_valid_o && !busy_o, "R8", "valid/busy low at done", {30'b0, addr_valid_o, busy_o}, 32'h0);
        addr_ready_i = 1'b0;
      end else if (addr_valid_o) begin
        int r, c;
        r = k / n; c = k % n;
        if (k == 0) begin
          check(src_addr_o == sb, "R2", "first src", src_addr_o, sb);
          check(dst_addr_o == f_dst(db, w, x, y, p3, 0, 0), p3 ? "R11" : "R2", "first dst",
                dst_addr_o, f_dst(db, w, x, y, p3, 0, 0));
        end else begin
          check(src_addr_o == sb + 32'(2 * k), "R4", "src contiguous", src_addr_o, sb + 32'(2 * k));
          check(dst_addr_o == f_dst(db, w, x, y, p3, r, c), (c == 0) ? "R6" : "R5", "dst step",
                dst_addr_o, f_dst(db, w, x, y, p3, r, c));
        end
        rdy = ($urandom % 4) != 0;
        addr_ready_i = rdy;
        if (poke && k == 1) begin
          // R10: start while busy, with different job parameters
          start_i = 1'b1; width_i = 1; height_i = 1; src_base_i = 32'hdead0000;
        end
        if (rdy) k++;
      end else begin
        check(1'b0, "R8", "valid dropped before done", 32'(k), 32'(total));
        addr_ready_i = 1'b0;
      end
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    addr_ready_i = 1'b0;
    check(seen_done, "R8", "done seen", 32'(seen_done), 32'd1);
    check(!done_o, "R8", "done one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    check(!addr_valid_o && !done_o && !busy_o, "R1", "outputs in reset",
          {29'b0, addr_valid_o, done_o, busy_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!addr_valid_o && !done_o && !busy_o, "R1", "outputs after reset",
          {29'b0, addr_valid_o, done_o, busy_o}, 32'h0);

    run_job(32'h1000, 32'h8000, 4, 3, 5, 2, 1'b0, 1'b0);
    run_job(32'h2000, 32'h9000, 5, 2, 3, 1, 1'b1, 1'b0);    // R11 odd width, 3 bytes
    run_job(32'h3000, 32'h0000, 320, 2, 0, 7, 1'b0, 1'b0);  // full width
    run_job(32'h3000, 32'h0000, 1, 1, 319, 239, 1'b1, 1'b0);
    run_job(32'hfffffff0, 32'hffffff00, 6, 3, 9, 0, 1'b1, 1'b0); // R12 wrap
    run_job(32'h4000, 32'h4000, 0, 5, 2, 2, 1'b0, 1'b0);    // R9 zero width
    run_job(32'h4000, 32'h4000, 7, 0, 2, 2, 1'b1, 1'b0);    // R9 zero height
    run_job(32'h5000, 32'h6000, 8, 3, 11, 4, 1'b0, 1'b1);   // R10
    for (int i = 0; i < 20; i++) begin
      int w, h, x, y;
      w = 1 + ($urandom % 40);
      h = 1 + ($urandom % 6);
      x = $urandom % (FB_W - w + 1);
      y = $urandom % 200;
      run_job($urandom & ~32'h1, $urandom & ~32'h1, w, h, x, y, 1'($urandom % 2), 1'b0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule